// File: doc/BRIEF.md
# I2C Master Byte Sequencer with Deferred Acknowledge

This block is a bit-level I2C master engine. A controller hands it one command at a time: open the bus, close the bus, send a byte or fetch a byte. The engine then drives the open-drain clock and data enables and samples the data line. The acknowledge slot that follows each byte is not clocked by the command that moved the byte. It is clocked as the first SCL pulse of the next command. A read therefore never needs to know whether another byte will follow. The acknowledge for a fetched byte is supplied by the read that follows it, or by the close command, which leaves data released and so gives a not-acknowledge.

Opening and closing the bus also recover it. The engine releases data and toggles the clock until it sees data high, and it gives up after a fixed number of pulses. Timing comes from a programmable quarter-bit tick. Every clock high and low phase lasts one step of two quarter ticks. After a read or a write the clock is left driven low until the next command. After an open it is left released with data driven low.

Top module: `i2c_defack_master`

## Requirements
- R1: Within a command, every high or low phase of the SCL enable lasts at least 2*(quarter_div+1) clock cycles (one step of two quarter-bit ticks).
- R2: Open (cmd_op=0) releases SDA and then pulses SCL until SDA is sampled high with SCL released. It then drives SDA low with SCL still released and completes, leaving scl_oe=0 and sda_oe=1.
- R3: If SDA is still low after MAX_REC (default 9) driven-low SCL pulses of an open or close, the engine completes with bus_err=1 and returns to idle. bus_err is cleared when the next command is accepted.
- R4: Close (cmd_op=1) runs the same release-and-pulse sequence as open, with one driven-low SCL pulse per sample that finds SDA low. It never drives SDA afterwards and completes with both enables deasserted.
- R5: Write (cmd_op=2) drives SDA low through a leading pulse, then presents cmd_wdata MSB first with one SCL pulse per bit, 9 SCL falls in all. It then releases SDA and leaves SCL driven low. rx_nack takes the SDA level sampled after the release while SCL is low (1 = not acknowledged).
- R6: Read (cmd_op=3) clocks a leading pulse with SDA driven low when cmd_ack_prev=1 and released when cmd_ack_prev=0. It then releases SDA and samples SDA at the end of each of 8 SCL high phases into rx_data, MSB first. It completes with SCL driven low and SDA released.
- R7: sda_oe changes while SCL stays released only during an open or close command.
- R8: done is a single-cycle pulse, raised in the cycle busy falls.
- R9: A command is taken only when cmd_valid is high while idle. cmd_valid during busy is ignored and does not disturb the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quarter_div | input | DIV_W | Clock cycles per quarter-bit tick, minus one |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 open, 1 close, 2 write, 3 read |
| cmd_ack_prev | input | 1 | Read only: 1 acknowledges the previous byte, 0 not-acknowledges it |
| cmd_wdata | input | 8 | Byte to send on write |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| sda_oe | output | 1 | 1 drives SDA low, 0 releases it |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Last open/close failed to see SDA high |
| rx_data | output | 8 | Last byte read |
| rx_nack | output | 1 | SDA level in the acknowledge slot after the last write |

## Verification
The checks assume that sda_in is already synchronous to clk. They also assume that read or write is issued only after an open or after another byte, never straight after an open with a read or from a closed bus, since the first data setup would otherwise move SDA while SCL is high. They further assume that quarter_div changes only while the engine is idle. The stimulus model follows this order: each random transaction is an open, an address write, and then writes or reads, followed by a close. The divider is changed only between transactions, and the bench slave changes SDA only on SCL falling edges, which it watches on the modelled bus wire.

// File: rtl/i2c_dam_pkg.sv
package i2c_dam_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_REC_HI,
    ST_REC_LO,
    ST_S_HOLD,
    ST_BIT_HI,
    ST_BIT_LO
  } st_e;

endpackage

// File: rtl/i2c_dam_tick.sv
// Quarter-bit timebase: mid marks the end of the first quarter of a step,
// step marks the end of the second one.
module i2c_dam_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             mid,
  output logic             step
);
  logic [DIV_W-1:0] cnt;
  logic             ph;
  logic             qtick;

  assign qtick = (cnt == div);
  assign mid   = qtick & ~ph;
  assign step  = qtick & ph;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (qtick) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_dam_shift.sv
// One register serves both directions: it shifts out MSB first on write
// and shifts sampled bits in at the bottom on read.
module i2c_dam_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] ldata,
  input  logic              shift,
  input  logic              sin,
  output logic              msb,
  output logic [BYTE_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst)        data <= '0;
    else if (load)  data <= ldata;
    else if (shift) data <= {data[BYTE_W-2:0], sin};
  end

  assign msb = data[BYTE_W-1];
endmodule

// File: rtl/i2c_dam_seq.sv
module i2c_dam_seq
  import i2c_dam_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MAX_REC = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  op_e  cmd_op,
  input  logic cmd_ack_prev,
  input  logic step,
  input  logic mid,
  input  logic sda_in,
  input  logic sr_msb,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic bus_err,
  output logic rx_nack,
  output logic tick_clr,
  output logic sr_load,
  output logic sr_shift,
  output logic rd_latch,
  output op_e  op_q
);
  localparam int KW = $clog2(BYTE_W + 1);
  localparam int RW = $clog2(MAX_REC + 1);
  localparam logic [KW-1:0] K_LAST = KW'(BYTE_W);
  localparam logic [RW-1:0] R_LAST = RW'(MAX_REC);

  st_e           st;
  logic [KW-1:0] k;
  logic [RW-1:0] rec;
  logic          accept;
  logic          is_bus_op;

  assign accept    = (st == ST_IDLE) && cmd_valid;
  assign is_bus_op = (op_q == OP_START) || (op_q == OP_STOP);
  assign tick_clr  = accept;
  assign sr_load   = accept;
  assign sr_shift  = ((st == ST_BIT_HI) && step && (op_q == OP_READ) && (k != '0)) ||
                     ((st == ST_BIT_LO) && mid && (op_q == OP_WRITE) && (k != K_LAST));
  assign rd_latch  = (st == ST_BIT_LO) && step && (op_q == OP_READ) && (k == K_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      bus_err <= 1'b0;
      rx_nack <= 1'b0;
      k       <= '0;
      rec     <= '0;
      op_q    <= OP_START;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            busy    <= 1'b1;
            bus_err <= 1'b0;
            op_q    <= cmd_op;
            k       <= '0;
            rec     <= '0;
            st      <= ST_SETUP;
            case (cmd_op)
              OP_WRITE: sda_oe <= 1'b1;
              OP_READ:  sda_oe <= cmd_ack_prev;
              default:  sda_oe <= 1'b0;
            endcase
          end
        end
        ST_SETUP: begin
          if (step) begin
            scl_oe <= 1'b0;
            st     <= is_bus_op ? ST_REC_HI : ST_BIT_HI;
          end
        end
        ST_REC_HI: begin
          if (step) begin
            if (sda_in) begin
              if (op_q == OP_START) begin
                sda_oe <= 1'b1;
                st     <= ST_S_HOLD;
              end else begin
                st   <= ST_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
              end
            end else if (rec == R_LAST) begin
              bus_err <= 1'b1;
              st      <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
            end else begin
              rec    <= rec + 1'b1;
              scl_oe <= 1'b1;
              st     <= ST_REC_LO;
            end
          end
        end
        ST_REC_LO: begin
          if (step) begin
            scl_oe <= 1'b0;
            st     <= ST_REC_HI;
          end
        end
        ST_S_HOLD: begin
          if (step) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        ST_BIT_HI: begin
          if (step) begin
            scl_oe <= 1'b1;
            st     <= ST_BIT_LO;
          end
        end
        ST_BIT_LO: begin
          if (mid) begin
            if (op_q == OP_WRITE) sda_oe <= (k == K_LAST) ? 1'b0 : ~sr_msb;
            else if (k == '0)     sda_oe <= 1'b0;
          end
          if (step) begin
            if (k == K_LAST) begin
              if (op_q == OP_WRITE) rx_nack <= sda_in;
              st   <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              k      <= k + 1'b1;
              scl_oe <= 1'b0;
              st     <= ST_BIT_HI;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_defack_master.sv
module i2c_defack_master
  import i2c_dam_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int MAX_REC = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  quarter_div,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_ack_prev,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              bus_err,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_nack
);
  logic              q_mid, q_step, t_clr;
  logic              sr_load, sr_shift, sr_msb, rd_latch;
  logic [BYTE_W-1:0] sr_data;
  op_e               op_q;

  i2c_dam_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .clear(t_clr), .div(quarter_div),
    .mid(q_mid), .step(q_step)
  );

  i2c_dam_shift #(.BYTE_W(BYTE_W)) shift_i (
    .clk(clk), .rst(rst), .load(sr_load), .ldata(cmd_wdata),
    .shift(sr_shift), .sin(sda_in), .msb(sr_msb), .data(sr_data)
  );

  i2c_dam_seq #(.BYTE_W(BYTE_W), .MAX_REC(MAX_REC)) seq_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
    .cmd_ack_prev(cmd_ack_prev), .step(q_step), .mid(q_mid), .sda_in(sda_in),
    .sr_msb(sr_msb), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .done(done), .bus_err(bus_err), .rx_nack(rx_nack), .tick_clr(t_clr),
    .sr_load(sr_load), .sr_shift(sr_shift), .rd_latch(rd_latch), .op_q(op_q)
  );

  always_ff @(posedge clk) begin
    if (rst)           rx_data <= '0;
    else if (rd_latch) rx_data <= sr_data;
  end
endmodule

// File: rtl/i2c_defack_master_chk.sv
module i2c_defack_master_chk #(
  parameter int DIV_W   = 16,
  parameter int MAX_REC = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic             bus_err,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic [1:0]       op
);
  logic        prev_scl, ph_valid;
  logic [31:0] run, min_len;
  logic [7:0]  rc;
  logic        bus_op;

  assign min_len = 2 * (32'(div) + 32'd1);
  assign bus_op  = (op == 2'd0) || (op == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_scl <= 1'b0;
      ph_valid <= 1'b0;
      run      <= 32'd0;
      rc       <= 8'd0;
    end else begin
      prev_scl <= scl_oe;
      if (scl_oe != prev_scl) begin
        run      <= 32'd1;
        ph_valid <= busy;
      end else if (run != 32'hFFFF_FFFF) begin
        run <= run + 32'd1;
      end
      if (!busy)                                  rc <= 8'd0;
      else if (scl_oe && !prev_scl && bus_op && rc != 8'hFF) rc <= rc + 8'd1;
    end
  end

  // R1
  scl_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_oe != prev_scl) && ph_valid |-> run >= min_len);
  // R2
  start_end_chk: assert property (@(posedge clk) disable iff (rst)
    done && (op == 2'd0) && !bus_err |-> !scl_oe && sda_oe);
  // R3
  err_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> done && bus_op);
  // R3
  rec_cap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> rc <= 8'(MAX_REC));
  // R4
  stop_end_chk: assert property (@(posedge clk) disable iff (rst)
    done && (op == 2'd1) && !bus_err |-> !scl_oe && !sda_oe);
  // R5
  byte_end_chk: assert property (@(posedge clk) disable iff (rst)
    done && op[1] |-> scl_oe && !sda_oe);
  // R7
  sda_stable_hi_chk: assert property (@(posedge clk) disable iff (rst)
    !scl_oe && !prev_scl && (sda_oe != $past(sda_oe)) |-> bus_op);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> $stable(op));
endmodule

bind i2c_defack_master i2c_defack_master_chk #(.DIV_W(DIV_W), .MAX_REC(MAX_REC)) chk_i (
  .clk(clk), .rst(rst), .div(quarter_div), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .bus_err(bus_err), .scl_oe(scl_oe), .sda_oe(sda_oe), .op(op_q)
);

// File: tb/i2c_defack_master_tb_top.sv
module i2c_defack_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] quarter_div = 16'd1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_ack_prev = 1'b0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       scl_oe, sda_oe, busy, done, bus_err, rx_nack;
  logic [7:0] rx_data;

  // bus and slave model
  logic       slv_low = 1'b0;
  int         fcnt = 0;
  int         mode = 0;          // 0 none, 1 write, 2 read
  logic       ack_give = 1'b1;
  logic [7:0] rbyte = 8'd0;
  int         hold_falls = 0;
  logic       mdrv [0:31];
  wire        scl_line = ~scl_oe;
  wire        sda_in   = ~sda_oe & ~slv_low;

  int n_chk = 0;
  int n_fail = 0;

  i2c_defack_master dut_i (
    .clk(clk), .rst(rst), .quarter_div(quarter_div), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ack_prev(cmd_ack_prev), .cmd_wdata(cmd_wdata),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .done(done), .bus_err(bus_err), .rx_data(rx_data), .rx_nack(rx_nack)
  );

  always #10 clk = ~clk;

  always @(negedge scl_line) begin
    fcnt = fcnt + 1;
    if (fcnt < 32) mdrv[fcnt] = sda_oe;
    case (mode)
      1:       slv_low = (fcnt == 9) ? ack_give : 1'b0;
      2:       slv_low = (fcnt >= 1 && fcnt <= 8) ? ~rbyte[8-fcnt] : 1'b0;
      default: slv_low = (fcnt < hold_falls);
    endcase
  end

  function automatic logic [7:0] written_byte();
    logic [7:0] b;
    for (int n = 2; n <= 9; n++) b[9-n] = ~mdrv[n];
    return b;
  endfunction

  function automatic int exp_stop_falls(input bit last_wr, input bit ack);
    return (last_wr && ack) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // issue one command and wait for done
  task automatic issue(input logic [1:0] op, input logic ackp, input logic [7:0] wd,
                       input bit poke_busy);
    int cyc;
    @(negedge clk);
    while (busy) @(negedge clk);
    fcnt = 0;
    mode = (op == 2'd2) ? 1 : (op == 2'd3) ? 2 : 0;
    cmd_op = op; cmd_ack_prev = ackp; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (poke_busy && cyc == 30) begin
        cmd_valid = 1'b1; cmd_op = 2'd3;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(done == 1'b1, "R8", "done seen", int'(done), 1);
  endtask

  task automatic do_start(input int exp_falls);
    issue(2'd0, 1'b0, 8'd0, 1'b0);
    chk(bus_err == 1'b0, "R2", "open error", int'(bus_err), 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b1, "R2", "open end state {scl,sda}",
        int'({scl_oe, sda_oe}), 1);
    chk(fcnt == exp_falls, "R2", "open recovery pulses", fcnt, exp_falls);
  endtask

  task automatic do_stop(input int exp_falls);
    issue(2'd1, 1'b0, 8'd0, 1'b0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0 && bus_err == 1'b0, "R4", "close end {scl,sda,err}",
        int'({scl_oe, sda_oe, bus_err}), 0);
    chk(fcnt == exp_falls, "R4", "close pulses", fcnt, exp_falls);
  endtask

  task automatic do_write(input logic [7:0] b, input bit ack, input bit poke);
    ack_give = ack;
    issue(2'd2, 1'b0, b, poke);
    chk(written_byte() == b, "R5", "bits on SDA", int'(written_byte()), int'(b));
    chk(mdrv[1] == 1'b1 && fcnt == 9, "R5", "lead pulse low and 9 falls", fcnt, 9);
    chk(rx_nack == !ack, "R5", "rx_nack", int'(rx_nack), int'(!ack));
    chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R5", "end {scl,sda}", int'({scl_oe, sda_oe}), 2);
  endtask

  task automatic do_read(input logic [7:0] b, input bit ackp);
    rbyte = b;
    issue(2'd3, ackp, 8'd0, 1'b0);
    chk(rx_data == b, "R6", "rx_data", int'(rx_data), int'(b));
    chk(mdrv[1] == ackp, "R6", "ack slot drive", int'(mdrv[1]), int'(ackp));
    chk(fcnt == 9 && scl_oe == 1'b1 && sda_oe == 1'b0, "R6", "falls / end state", fcnt, 9);
  endtask

  initial begin
    int unsigned s;
    bit last_wr, last_ack;
    s = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !scl_oe && !sda_oe && !bus_err, "R8", "reset state",
        int'({busy, done, scl_oe, sda_oe, bus_err}), 0);

    // stuck SDA: open must give up after 9 pulses
    hold_falls = 255; slv_low = 1'b1;
    issue(2'd0, 1'b0, 8'd0, 1'b0);
    chk(bus_err == 1'b1, "R3", "bus_err after stuck SDA", int'(bus_err), 1);
    chk(fcnt == 9, "R3", "recovery pulse count", fcnt, 9);
    @(negedge clk);
    chk(!done && !busy, "R8", "done one cycle", int'(done), 0);
    slv_low = 1'b0; hold_falls = 0;
    do_stop(0);
    chk(bus_err == 1'b0, "R3", "bus_err cleared by next command", int'(bus_err), 0);

    // SDA held for 3 falls then freed: open recovers
    hold_falls = 3; slv_low = 1'b1;
    do_start(3);
    hold_falls = 0;
    // directed corner bytes, command poked while busy
    do_write(8'h00, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(!busy, "R9", "poke while busy ignored", int'(busy), 0);
    do_write(8'hFF, 1'b0, 1'b0);
    do_stop(exp_stop_falls(1'b1, 1'b0));
    do_start(0);
    do_write(8'hA5, 1'b1, 1'b0);
    do_read(8'h80, 1'b1);
    do_read(8'h01, 1'b0);
    do_stop(0);

    // random transactions
    for (int t = 0; t < 10; t++) begin
      int nb;
      quarter_div = 16'($urandom_range(0, 3));
      do_start(0);
      last_ack = ($urandom_range(0, 3) != 0);
      do_write(8'($urandom), last_ack, 1'b0);
      last_wr = 1'b1;
      nb = $urandom_range(1, 3);
      if ($urandom_range(0, 1) == 1) begin
        for (int i = 0; i < nb; i++) begin
          last_ack = ($urandom_range(0, 3) != 0);
          do_write(8'($urandom), last_ack, 1'b0);
        end
      end else begin
        for (int i = 0; i < nb; i++) do_read(8'($urandom), 1'($urandom));
        last_wr = 1'b0;
      end
      do_stop(exp_stop_falls(last_wr, last_ack));
    end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    finish_run();
  end
endmodule